// File: doc/BRIEF.md
# Microcoded Call/Return Sequencer

This block steps a 16-bit processor through near subroutine call and return as a short chain of micro-operations. A decoder supplies a 5-bit entry address and the PARAM2 operand. On each step pulse the block reads a 32-bit microword from an internal ROM and slices it into control fields. These fields choose the two ALU operand sources, the ALU function, where the result goes, the register read and write addresses, the memory-operand mode, the next processor state and the next micro-address. The block then performs that micro-operation on a small built-in datapath. The datapath holds a register file containing the stack pointer, a 15-bit word program counter with an alignment flag, PARAM1, PARAM2 and a word memory.

The call sequence runs from micro-address 1 and the return sequence from micro-address 4. Micro-address 0 means that no sequence is running. When a microword names 0 as its successor, the step that executes it finishes the sequence. The block then pulses `done` for one cycle and goes back to idle.

Top module: `ucode_callret`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done` and `uaddr` are 0, and `pc_out` and `align_out` are 0.
- R2: When `start` is high while idle and `entry_addr` is nonzero, the block becomes busy with `uaddr` equal to `entry_addr`. A `start` with entry 0 has no effect, and so does a `start` while busy.
- R3: The micro-address, stack pointer and program counter change only on a cycle with `step` high while busy (or, for SP and PC, on `init_we`). Without `step` they hold.
- R4: Call step 1 writes SP minus PARAM2 to register 4'b1100 (the stack pointer), because destination code 3'b011 writes the register file. It also loads `imm_in` into PARAM1, since next-state code 2'b01 means a 16-bit immediate load.
- R5: Call step 2 writes {PC, align} to the memory word at index SP[8:1], using the SP left by step 1. Destination code 3'b110 selects stack memory.
- R6: Call step 3 computes sum = PARAM1 + {PC, align}. PC takes sum[15:1] and align takes sum[0] (destination code 3'b101). After this step `busy` is 0, `uaddr` is 0 and `done` is 1.
- R7: The return sequence (entry 4) first loads PC and align from the memory word at SP[8:1], then adds PARAM2 to SP, and then ends with `done`.
- R8: `done` is high for exactly one cycle, and only after the step that ends a sequence.
- R9: `proc_state` shows the next-state field of the current microword: 2'b01 at call entry, 2'b11 (memory read) at return entry, and 2'b00 at return step 2.
- R10: Only a stack-memory destination writes memory, so the return sequence leaves the saved word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_we | input | 1 | Loads init_sp into SP, and init_pc and init_align into PC |
| init_sp | input | 16 | Stack pointer preset |
| init_pc | input | 15 | Program counter preset (word address) |
| init_align | input | 1 | Alignment flag preset |
| start | input | 1 | Starts a sequence at entry_addr |
| entry_addr | input | 5 | Entry micro-address from the decoder |
| param2_in | input | 16 | PARAM2 operand, captured at start |
| imm_in | input | 16 | Immediate operand (call displacement) |
| step | input | 1 | Step enable from the surrounding state machine |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| uaddr | output | 5 | Current micro-address |
| proc_state | output | 2 | Next-state field of the current microword |
| uword | output | 32 | Current microword |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 15 | Program counter |
| align_out | output | 1 | Alignment flag |
| probe_addr | input | 8 | Memory word index to observe |
| probe_data | output | 16 | Memory word at probe_addr |

## Verification
The assertions assume that `init_we` is never raised while a sequence is running, and that `step` is the only thing that moves a running sequence. The hold properties treat any change of SP or PC outside a step or an init as an error. The stimulus raises `init_we` only between sequences, issues `start` at most once per sequence (apart from deliberate rejected starts), and drives all inputs half a clock away from the sampling edge. It sweeps the stack pointer, program counter, alignment flag, displacement and PARAM2 values, including SP wrap-around and carries into the alignment bit.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UA_W  = 5;
  localparam int UW_W  = 32;
  localparam int RA_W  = 4;
  localparam int NXT_W = 6;

  localparam logic [2:0] FN_ADD  = 3'b000;
  localparam logic [2:0] FN_SUB  = 3'b001;
  localparam logic [2:0] FN_XOR  = 3'b100;
  localparam logic [2:0] FN_ADDS = 3'b101;

  localparam logic [2:0] DST_REG = 3'b011;
  localparam logic [2:0] DST_PC  = 3'b101;
  localparam logic [2:0] DST_STK = 3'b110;

  localparam logic [1:0] NS_EXEC  = 2'b00;
  localparam logic [1:0] NS_IMM16 = 2'b01;
  localparam logic [1:0] NS_IMM8  = 2'b10;
  localparam logic [1:0] NS_MEMRD = 2'b11;

  localparam logic [1:0] SRC_P     = 2'b00;
  localparam logic [1:0] SRC_REG   = 2'b01;
  localparam logic [1:0] SRC_PC    = 2'b10;
  localparam logic [1:0] SRC_ZERO  = 2'b11;

  localparam logic [2:0] MODE_REG   = 3'b011;
  localparam logic [2:0] MODE_STACK = 3'b110;
  localparam logic [RA_W-1:0] SP_ADDR = 4'b1100;

  function automatic logic [UW_W-1:0] mk_uword(
    input logic [2:0] mode, input logic [RA_W-1:0] rd, input logic [2:0] fn,
    input logic [2:0] dst, input logic [1:0] bsel, input logic [1:0] asel,
    input logic [RA_W-1:0] wr, input logic [1:0] nxs, input logic [NXT_W-1:0] nxt);
    return {3'b000, mode, rd, fn, dst, bsel, asel, wr, nxs, nxt};
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output logic [UW_W-1:0] word
);
  always_comb begin
    case (addr)
      5'd1: word = mk_uword(MODE_REG, SP_ADDR, FN_SUB, DST_REG, SRC_P, SRC_REG,
                            SP_ADDR, NS_IMM16, 6'd2);
      5'd2: word = mk_uword(MODE_REG, 4'd0, FN_ADD, DST_STK, SRC_PC, SRC_ZERO,
                            4'd0, NS_EXEC, 6'd3);
      5'd3: word = mk_uword(MODE_REG, 4'd0, FN_ADD, DST_PC, SRC_PC, SRC_P,
                            4'd0, NS_EXEC, 6'd0);
      5'd4: word = mk_uword(MODE_STACK, 4'd0, FN_ADD, DST_PC, SRC_ZERO, SRC_P,
                            4'd0, NS_MEMRD, 6'd5);
      5'd5: word = mk_uword(MODE_REG, SP_ADDR, FN_ADD, DST_REG, SRC_P, SRC_REG,
                            SP_ADDR, NS_EXEC, 6'd0);
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/mseq_alu.sv
module mseq_alu
  import mseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    fn,
  output logic [DW-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_XOR:  y = a ^ b;
      FN_ADDS: y = a + {{(DW-8){b[7]}}, b[7:0]};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mseq_datapath.sv
module mseq_datapath
  import mseq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS),
  localparam int NREGS    = 2**RA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_we,
  input  logic [DW-1:0]   init_sp,
  input  logic [DW-2:0]   init_pc,
  input  logic            init_align,
  input  logic            load_p2,
  input  logic [DW-1:0]   p2_in,
  input  logic [DW-1:0]   imm_in,
  input  logic            step_en,
  input  logic [2:0]      mode,
  input  logic [RA_W-1:0] rd_addr,
  input  logic [2:0]      fn,
  input  logic [2:0]      dst,
  input  logic [1:0]      bsel,
  input  logic [1:0]      asel,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [1:0]      nxs,
  input  logic [AW-1:0]   probe_addr,
  output logic [DW-1:0]   sp_out,
  output logic [DW-2:0]   pc_out,
  output logic            align_out,
  output logic [DW-1:0]   probe_data
);
  logic [DW-1:0] rf  [NREGS];
  logic [DW-1:0] mem [MEM_WORDS];
  logic [DW-2:0] pc_q, pc_d;
  logic          al_q, al_d;
  logic [DW-1:0] p1_q, p1_d, p2_q, p2_d;
  logic [DW-1:0] sp, rd1, mem_rd, p1_eff, pc_word, opa, opb, alu_y;
  logic [AW-1:0] sp_idx;
  logic          stack_rd;

  assign sp       = rf[SP_ADDR];
  assign rd1      = rf[rd_addr];
  assign sp_idx   = sp[AW:1];
  assign mem_rd   = mem[sp_idx];
  assign stack_rd = (mode == MODE_STACK) && (nxs == NS_MEMRD);
  assign p1_eff   = stack_rd ? mem_rd : p1_q;
  assign pc_word  = {pc_q, al_q};

  always_comb begin
    case (asel)
      SRC_P:   opa = p1_eff;
      SRC_REG: opa = rd1;
      SRC_PC:  opa = pc_word;
      default: opa = '0;
    endcase
    case (bsel)
      SRC_P:   opb = p2_q;
      SRC_REG: opb = rd1;
      SRC_PC:  opb = pc_word;
      default: opb = '0;
    endcase
  end

  mseq_alu #(.DW(DW)) u_alu (.a(opa), .b(opb), .fn(fn), .y(alu_y));

  always_comb begin
    p1_d = p1_q;
    if (step_en) begin
      case (nxs)
        NS_IMM16: p1_d = imm_in;
        NS_IMM8:  p1_d = {{(DW-8){imm_in[7]}}, imm_in[7:0]};
        NS_MEMRD: if (stack_rd) p1_d = mem_rd;
        default:  p1_d = p1_q;
      endcase
    end
    p2_d = load_p2 ? p2_in : p2_q;
    pc_d = pc_q;
    al_d = al_q;
    if (init_we) begin
      pc_d = init_pc;
      al_d = init_align;
    end else if (step_en && dst == DST_PC) begin
      {pc_d, al_d} = alu_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      al_q <= 1'b0;
      p1_q <= '0;
      p2_q <= '0;
    end else begin
      pc_q <= pc_d;
      al_q <= al_d;
      p1_q <= p1_d;
      p2_q <= p2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (init_we) rf[SP_ADDR] <= init_sp;
    else if (step_en && dst == DST_REG) rf[wr_addr] <= alu_y;
  end

  always_ff @(posedge clk) begin
    if (step_en && dst == DST_STK) mem[sp_idx] <= alu_y;
  end

  assign sp_out     = sp;
  assign pc_out     = pc_q;
  assign align_out  = al_q;
  assign probe_data = mem[probe_addr];

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !init_we) |=> $stable({pc_out, align_out}));  // R3
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !init_we) |=> $stable(sp_out));  // R3
endmodule

// File: rtl/ucode_callret.sv
module ucode_callret
  import mseq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_we,
  input  logic [DW-1:0]   init_sp,
  input  logic [DW-2:0]   init_pc,
  input  logic            init_align,
  input  logic            start,
  input  logic [UA_W-1:0] entry_addr,
  input  logic [DW-1:0]   param2_in,
  input  logic [DW-1:0]   imm_in,
  input  logic            step,
  output logic            busy,
  output logic            done,
  output logic [UA_W-1:0] uaddr,
  output logic [1:0]      proc_state,
  output logic [UW_W-1:0] uword,
  output logic [DW-1:0]   sp_out,
  output logic [DW-2:0]   pc_out,
  output logic            align_out,
  input  logic [AW-1:0]   probe_addr,
  output logic [DW-1:0]   probe_data
);
  logic [1:0]       rs_q;
  logic             rst_ns;
  logic             busy_q, busy_d, done_q, done_d;
  logic [UA_W-1:0]  ua_q, ua_d;
  logic [NXT_W-1:0] nxt;
  logic             start_acc, step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  mseq_rom u_rom (.addr(ua_q), .word(uword));

  assign nxt       = uword[5:0];
  assign start_acc = start && !busy_q && (entry_addr != '0);
  assign step_en   = busy_q && step;

  always_comb begin
    busy_d = busy_q;
    ua_d   = ua_q;
    done_d = 1'b0;
    if (start_acc) begin
      busy_d = 1'b1;
      ua_d   = entry_addr;
    end else if (step_en) begin
      if (nxt == '0) begin
        busy_d = 1'b0;
        ua_d   = '0;
        done_d = 1'b1;
      end else begin
        ua_d = nxt[UA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ua_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ua_q   <= ua_d;
    end
  end

  mseq_datapath #(.DW(DW), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_ns),
    .init_we(init_we), .init_sp(init_sp), .init_pc(init_pc), .init_align(init_align),
    .load_p2(start_acc), .p2_in(param2_in), .imm_in(imm_in), .step_en(step_en),
    .mode(uword[28:26]), .rd_addr(uword[25:22]), .fn(uword[21:19]),
    .dst(uword[18:16]), .bsel(uword[15:14]), .asel(uword[13:12]),
    .wr_addr(uword[11:8]), .nxs(uword[7:6]), .probe_addr(probe_addr),
    .sp_out(sp_out), .pc_out(pc_out), .align_out(align_out), .probe_data(probe_data)
  );

  assign busy       = busy_q;
  assign done       = done_q;
  assign uaddr      = ua_q;
  assign proc_state = uword[7:6];

  AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy) |-> (uaddr != '0));  // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !step) |=> $stable(uaddr));  // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> (!busy && uaddr == '0));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);  // R8
endmodule

// File: tb/ucode_callret_test.sv
module ucode_callret_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_we = 1'b0;
  logic [15:0] init_sp = '0;
  logic [14:0] init_pc = '0;
  logic        init_align = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  entry_addr = '0;
  logic [15:0] param2_in = '0;
  logic [15:0] imm_in = '0;
  logic        step = 1'b0;
  logic [7:0]  probe_addr = '0;
  logic        busy, done, align_out;
  logic [4:0]  uaddr;
  logic [1:0]  proc_state;
  logic [31:0] uword;
  logic [15:0] sp_out, probe_data;
  logic [14:0] pc_out;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ucode_callret uut (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_sp(init_sp),
    .init_pc(init_pc), .init_align(init_align), .start(start),
    .entry_addr(entry_addr), .param2_in(param2_in), .imm_in(imm_in),
    .step(step), .busy(busy), .done(done), .uaddr(uaddr),
    .proc_state(proc_state), .uword(uword), .sp_out(sp_out),
    .pc_out(pc_out), .align_out(align_out), .probe_addr(probe_addr),
    .probe_data(probe_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic [15:0] s, input logic [14:0] p, input logic a);
    init_sp = s; init_pc = p; init_align = a; init_we = 1'b1;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic do_start(input logic [4:0] e, input logic [15:0] p2);
    entry_addr = e; param2_in = p2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] sp_l [4] = '{16'h0100, 16'h0042, 16'h01FE, 16'h0002};
    logic [14:0] pc_l [4] = '{15'h0000, 15'h1234, 15'h7FFF, 15'h0001};
    logic [15:0] dp_l [4] = '{16'h0010, 16'hFFFE, 16'h8001, 16'h0003};
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 uaddr", uaddr, 0);
    chk("R1 pc", {pc_out, align_out}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after release", busy, 0); chk("R1 uaddr after release", uaddr, 0);

    do_init(16'h0100, 15'h0010, 1'b0);
    do_step();
    chk("R3 idle step leaves pc", {pc_out, align_out}, 16'h0020);
    chk("R3 idle step leaves sp", sp_out, 16'h0100);
    do_start(5'd0, 16'd2);
    chk("R2 entry 0 ignored", busy, 0);
    do_start(5'd1, 16'd2);
    chk("R2 busy", busy, 1); chk("R2 uaddr", uaddr, 1);
    repeat (3) @(negedge clk);
    chk("R3 uaddr held", uaddr, 1); chk("R3 sp held", sp_out, 16'h0100);
    do_start(5'd4, 16'd2);
    chk("R2 start while busy ignored", uaddr, 1);
    repeat (3) do_step();
    @(negedge clk);

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int a = 0; a < 2; a++)
          for (int k = 0; k < 4; k++) begin
            logic [15:0] sp0, p2, sp1, ret, sum;
            sp0 = sp_l[i]; p2 = (a == 1) ? 16'd4 : 16'd2;
            sp1 = sp0 - p2; ret = {pc_l[j], a[0]}; sum = dp_l[k] + ret;
            do_init(sp0, pc_l[j], a[0]);
            imm_in = dp_l[k];
            do_start(5'd1, p2);
            chk("R9 call entry state", proc_state, 2'b01);
            do_step();
            chk("R4 sp after step1", sp_out, sp1);
            chk("R8 no done mid-sequence", done, 0);
            do_step();
            probe_addr = sp1[8:1];
            #1 chk("R5 saved return word", probe_data, ret);
            do_step();
            chk("R6 pc", pc_out, sum[15:1]); chk("R6 align", align_out, sum[0]);
            chk("R6 done", {done, busy, uaddr}, {1'b1, 1'b0, 5'd0});
            @(negedge clk);
            chk("R8 done one cycle", done, 0);
            do_start(5'd4, p2);
            chk("R9 return entry state", proc_state, 2'b11);
            do_step();
            chk("R7 pc restored", {pc_out, align_out}, ret);
            chk("R9 return step2 state", proc_state, 2'b00);
            do_step();
            chk("R7 sp restored", sp_out, sp0);
            chk("R7 done", done, 1);
            chk("R10 saved word kept", probe_data, ret);
            @(negedge clk);
          end
    finish_run();
  end
endmodule